// File: doc/BRIEF.md
# Priority Region Memory Protection Checker

This block checks every instruction fetch and data access against a set of programmable address regions and decides whether the access may proceed. Each region has an enable bit, a base address, a power-of-two size code, read and write permissions for privileged and unprivileged code, and a no-execute flag. The check is combinational. A fault from that check is held for software in a status register one clock later.

Regions may overlap. When they do, the enabled matching region with the highest number decides the outcome. An address that matches no enabled region falls back to a default map, which allows privileged code and faults unprivileged code. Until a global enable bit is set, the checker lets every access through.

Top module: `prio_mpu`

## Requirements
- R1: After reset, all regions are disabled and the global enable is 0. The fault status is clear and every register reads 0. While the global enable is 0, every access is allowed, `chk_hit_o` is low and `chk_region_o` is 0.
- R2: The size code N sits in attribute bits 5:1 and gives a region of 2^(N+1) bytes. A region with a code from 0 to 3 never matches. Code 31 covers the whole 4 GB space.
- R3: Base bits 4:0 are dropped on a write and read back as 0. Address bits below the region size are ignored when comparing an address with the base.
- R4: When several enabled regions match, the one with the highest number decides. `chk_hit_o` is high and `chk_region_o` carries that number.
- R5: Attribute bits 8, 9, 10 and 11 grant privileged read, privileged write, unprivileged read and unprivileged write. A read (access code 01) needs the read bit for the current privilege. A write (code 10 or 11) needs the write bit.
- R6: An instruction fetch (access code 00) needs the read bit for the current privilege, and it also needs the no-execute bit (attribute bit 12) of the deciding region to be clear.
- R7: When the global enable is set and no enabled region matches, a privileged access is allowed and an unprivileged access faults.
- R8: `chk_fault_o` is `chk_valid_i` and not allowed. On a fault, the next clock edge captures the address, access code and privilege, but only if the status is empty or is being cleared in that cycle. Otherwise the status holds the first fault. Writing 1 to bit 0 of the status register clears it. Nothing is captured while `chk_valid_i` is low.
- R9: Register map. Word 2i holds the base of region i and word 2i+1 holds its attributes. Word 2N holds the global enable in bit 0. Word 2N+1 is the status: valid in bit 0, access code in bits 2:1, privilege in bit 3. Word 2N+2 is the fault address. Reads are combinational.
- R10: Attribute bit 0 is the region enable. A region with this bit cleared never matches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_addr_i | input | CA_W (5) | Register word address |
| cfg_wdata_i | input | 32 | Register write data |
| cfg_rdata_o | output | 32 | Register read data, combinational |
| chk_valid_i | input | 1 | Access present this cycle |
| chk_addr_i | input | 32 | Access address |
| chk_acc_i | input | 2 | 00 fetch, 01 read, 1x write |
| chk_priv_i | input | 1 | Access is privileged |
| chk_allow_o | output | 1 | Access permitted |
| chk_fault_o | output | 1 | Valid access refused |
| chk_hit_o | output | 1 | An enabled region matched |
| chk_region_o | output | IDX_W (3) | Deciding region number |
| flt_valid_o | output | 1 | Fault status held |
| flt_addr_o | output | 32 | Captured fault address |
| flt_acc_o | output | 2 | Captured access code |
| flt_priv_o | output | 1 | Captured privilege |

## Verification
The directed patterns are placed to separate the outcomes.
- Addresses inside a small region nested in a large one show whether the higher number wins. Swapping privilege and access type on the same address isolates each permission bit.
- Addresses one byte past a region's end, together with a written base carrying low garbage bits, expose mask and alignment errors.
- A too-small size code and the default map are told apart with both privilege levels.
- A 4 GB region enabled late shows that it overrides everything below it.

Random accesses over these windows and over the whole address space are then compared, cycle by cycle, with a behavioural model that matches by integer division. The fault status is followed through a first capture, a second fault that must not overwrite it, a write-one-to-clear, and a faulting pattern presented with the valid strobe low.

// File: rtl/prio_mpu_pkg.sv
package prio_mpu_pkg;
  localparam int ADDR_W   = 32;
  localparam int CODE_W   = 5;
  localparam int MIN_CODE = 4;
  localparam int BASE_LSB = 5;

  typedef struct packed {
    logic              en;
    logic [ADDR_W-1:0] base;
    logic [CODE_W-1:0] code;
    logic              pr;
    logic              pw;
    logic              ur;
    logic              uw;
    logic              xn;
  } region_t;

  // mask of address bits that take part in the compare for size code
  function automatic logic [ADDR_W-1:0] size_mask(logic [CODE_W-1:0] code);
    logic [ADDR_W:0] m;
    m = {(ADDR_W+1){1'b1}} << (int'(code) + 1);
    return m[ADDR_W-1:0];
  endfunction
endpackage

// File: rtl/mpu_cfg_regs.sv
module mpu_cfg_regs
  import prio_mpu_pkg::*;
#(
  parameter int NUM_REGIONS = 8,
  parameter int IDX_W = $clog2(NUM_REGIONS),
  parameter int CA_W  = IDX_W + 2
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             we_i,
  input  logic [CA_W-1:0]                  addr_i,
  input  logic [31:0]                      wdata_i,
  input  logic                             flt_valid_i,
  input  logic [1:0]                       flt_acc_i,
  input  logic                             flt_priv_i,
  input  logic [ADDR_W-1:0]                flt_addr_i,
  output logic [31:0]                      rdata_o,
  output region_t [NUM_REGIONS-1:0]        regions_o,
  output logic                             glb_en_o,
  output logic                             clr_o
);
  localparam logic [CA_W-1:0] CTRL_A = CA_W'(2*NUM_REGIONS);
  localparam logic [CA_W-1:0] STAT_A = CA_W'(2*NUM_REGIONS + 1);
  localparam logic [CA_W-1:0] FADR_A = CA_W'(2*NUM_REGIONS + 2);

  for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_reg
    region_t reg_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        reg_q <= '0;
      end else if (we_i && addr_i == CA_W'(2*g)) begin
        reg_q.base <= {wdata_i[ADDR_W-1:BASE_LSB], {BASE_LSB{1'b0}}};
      end else if (we_i && addr_i == CA_W'(2*g+1)) begin
        reg_q.en   <= wdata_i[0];
        reg_q.code <= wdata_i[5:1];
        reg_q.pr   <= wdata_i[8];
        reg_q.pw   <= wdata_i[9];
        reg_q.ur   <= wdata_i[10];
        reg_q.uw   <= wdata_i[11];
        reg_q.xn   <= wdata_i[12];
      end
    end
    assign regions_o[g] = reg_q;
  end

  logic glb_en_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        glb_en_q <= 1'b0;
    else if (we_i && addr_i == CTRL_A)  glb_en_q <= wdata_i[0];
  end
  assign glb_en_o = glb_en_q;
  assign clr_o    = we_i && (addr_i == STAT_A) && wdata_i[0];

  region_t rd_reg;
  always_comb begin
    rd_reg  = regions_o[addr_i[IDX_W:1]];
    rdata_o = '0;
    if (int'(addr_i) < 2*NUM_REGIONS) begin
      if (!addr_i[0]) rdata_o = rd_reg.base;
      else rdata_o = {19'b0, rd_reg.xn, rd_reg.uw, rd_reg.ur, rd_reg.pw, rd_reg.pr,
                      2'b0, rd_reg.code, rd_reg.en};
    end else if (addr_i == CTRL_A) begin
      rdata_o = {31'b0, glb_en_q};
    end else if (addr_i == STAT_A) begin
      rdata_o = {28'b0, flt_priv_i, flt_acc_i, flt_valid_i};
    end else if (addr_i == FADR_A) begin
      rdata_o = flt_addr_i;
    end
  end
endmodule

// File: rtl/mpu_region_match.sv
module mpu_region_match
  import prio_mpu_pkg::*;
(
  input  region_t           region_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o
);
  logic [ADDR_W-1:0] mask;
  assign mask  = size_mask(region_i.code);
  assign hit_o = region_i.en && (int'(region_i.code) >= MIN_CODE) &&
                 ((addr_i & mask) == (region_i.base & mask));
endmodule

// File: rtl/mpu_prio_sel.sv
module mpu_prio_sel #(
  parameter int NUM_REGIONS = 8,
  parameter int IDX_W = $clog2(NUM_REGIONS)
) (
  input  logic [NUM_REGIONS-1:0] hit_i,
  output logic                   any_o,
  output logic [IDX_W-1:0]       idx_o
);
  // ascending scan: the last hit seen, i.e. highest number, wins
  always_comb begin
    any_o = 1'b0;
    idx_o = '0;
    for (int i = 0; i < NUM_REGIONS; i++) begin
      if (hit_i[i]) begin
        any_o = 1'b1;
        idx_o = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/mpu_fault_status.sv
module mpu_fault_status
  import prio_mpu_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fault_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [1:0]        acc_i,
  input  logic              priv_i,
  input  logic              clr_i,
  output logic              valid_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [1:0]        acc_o,
  output logic              priv_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      addr_o  <= '0;
      acc_o   <= '0;
      priv_o  <= 1'b0;
    end else if (fault_i && (!valid_o || clr_i)) begin
      valid_o <= 1'b1;
      addr_o  <= addr_i;
      acc_o   <= acc_i;
      priv_o  <= priv_i;
    end else if (clr_i) begin
      valid_o <= 1'b0;
    end
  end
endmodule

// File: rtl/prio_mpu.sv
module prio_mpu
  import prio_mpu_pkg::*;
#(
  parameter int NUM_REGIONS = 8,
  localparam int IDX_W = $clog2(NUM_REGIONS),
  localparam int CA_W  = IDX_W + 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [CA_W-1:0]   cfg_addr_i,
  input  logic [31:0]       cfg_wdata_i,
  output logic [31:0]       cfg_rdata_o,
  input  logic              chk_valid_i,
  input  logic [ADDR_W-1:0] chk_addr_i,
  input  logic [1:0]        chk_acc_i,
  input  logic              chk_priv_i,
  output logic              chk_allow_o,
  output logic              chk_fault_o,
  output logic              chk_hit_o,
  output logic [IDX_W-1:0]  chk_region_o,
  output logic              flt_valid_o,
  output logic [ADDR_W-1:0] flt_addr_o,
  output logic [1:0]        flt_acc_o,
  output logic              flt_priv_o
);
  region_t [NUM_REGIONS-1:0] regions;
  logic                      glb_en;
  logic                      clr;
  logic [NUM_REGIONS-1:0]    hits;
  logic                      any_hit;
  logic [IDX_W-1:0]          win_idx;
  region_t                   win;
  logic                      is_fetch, is_write, perm_ok, allow;

  mpu_cfg_regs #(.NUM_REGIONS(NUM_REGIONS), .IDX_W(IDX_W), .CA_W(CA_W)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (cfg_we_i),
    .addr_i     (cfg_addr_i),
    .wdata_i    (cfg_wdata_i),
    .flt_valid_i(flt_valid_o),
    .flt_acc_i  (flt_acc_o),
    .flt_priv_i (flt_priv_o),
    .flt_addr_i (flt_addr_o),
    .rdata_o    (cfg_rdata_o),
    .regions_o  (regions),
    .glb_en_o   (glb_en),
    .clr_o      (clr)
  );

  for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_match
    mpu_region_match u_match (
      .region_i(regions[g]),
      .addr_i  (chk_addr_i),
      .hit_o   (hits[g])
    );
  end

  mpu_prio_sel #(.NUM_REGIONS(NUM_REGIONS), .IDX_W(IDX_W)) u_sel (
    .hit_i(hits),
    .any_o(any_hit),
    .idx_o(win_idx)
  );

  assign win      = regions[win_idx];
  assign is_fetch = (chk_acc_i == 2'b00);
  assign is_write = chk_acc_i[1];

  always_comb begin
    if (is_write) perm_ok = chk_priv_i ? win.pw : win.uw;
    else          perm_ok = chk_priv_i ? win.pr : win.ur;
    if (is_fetch && win.xn) perm_ok = 1'b0;
  end

  always_comb begin
    if (!glb_en)      allow = 1'b1;
    else if (any_hit) allow = perm_ok;
    else              allow = chk_priv_i;
  end

  assign chk_allow_o  = allow;
  assign chk_fault_o  = chk_valid_i && !allow;
  assign chk_hit_o    = glb_en && any_hit;
  assign chk_region_o = glb_en ? win_idx : '0;

  mpu_fault_status u_status (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .fault_i(chk_fault_o),
    .addr_i (chk_addr_i),
    .acc_i  (chk_acc_i),
    .priv_i (chk_priv_i),
    .clr_i  (clr),
    .valid_o(flt_valid_o),
    .addr_o (flt_addr_o),
    .acc_o  (flt_acc_o),
    .priv_o (flt_priv_o)
  );
endmodule

// File: rtl/prio_mpu_chk.sv
module prio_mpu_chk #(
  parameter int NUM_REGIONS = 8,
  parameter int IDX_W = $clog2(NUM_REGIONS),
  parameter int CA_W  = IDX_W + 2
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cfg_we_i,
  input logic [CA_W-1:0]  cfg_addr_i,
  input logic [31:0]      cfg_wdata_i,
  input logic             chk_valid_i,
  input logic [31:0]      chk_addr_i,
  input logic [1:0]       chk_acc_i,
  input logic             chk_priv_i,
  input logic             chk_allow_o,
  input logic             chk_fault_o,
  input logic             chk_hit_o,
  input logic             flt_valid_o,
  input logic [31:0]      flt_addr_o,
  input logic [1:0]       flt_acc_o,
  input logic             glb_en
);
  logic clr_w;
  assign clr_w = cfg_we_i && (cfg_addr_i == CA_W'(2*NUM_REGIONS + 1)) && cfg_wdata_i[0];

  p_off_allow_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chk_valid_i && !glb_en |-> chk_allow_o && !chk_hit_o);

  p_fault_needs_valid_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chk_fault_o |-> chk_valid_i && !chk_allow_o);

  p_default_map_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chk_valid_i && glb_en && !chk_hit_o |-> chk_allow_o == chk_priv_i);

  p_capture_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chk_fault_o && !flt_valid_o |=>
      flt_valid_o && flt_addr_o == $past(chk_addr_i) && flt_acc_o == $past(chk_acc_i));

  p_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flt_valid_o && !clr_w |=> flt_valid_o && $stable(flt_addr_o));

  p_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_w && !chk_fault_o |=> !flt_valid_o);
endmodule

bind prio_mpu prio_mpu_chk #(.NUM_REGIONS(NUM_REGIONS)) u_chk (.*);

// File: tb/prio_mpu_test.sv
`timescale 1ns/1ps
module prio_mpu_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_we_i = 1'b0;
  logic [4:0]  cfg_addr_i = '0;
  logic [31:0] cfg_wdata_i = '0;
  logic [31:0] cfg_rdata_o;
  logic        chk_valid_i = 1'b0;
  logic [31:0] chk_addr_i = '0;
  logic [1:0]  chk_acc_i = '0;
  logic        chk_priv_i = 1'b0;
  logic        chk_allow_o, chk_fault_o, chk_hit_o;
  logic [2:0]  chk_region_o;
  logic        flt_valid_o;
  logic [31:0] flt_addr_o;
  logic [1:0]  flt_acc_o;
  logic        flt_priv_o;

  always #10 clk_i = ~clk_i;

  prio_mpu uut (.*);

  int n_chk = 0;
  int n_err = 0;
  bit run = 1'b0;
  bit done = 1'b0;

  // behavioural reference model
  logic        m_en   [8];
  logic [31:0] m_base [8];
  logic [4:0]  m_code [8];
  logic [3:0]  m_perm [8];
  logic        m_xn   [8];
  logic        m_glb;
  logic        m_fv;
  logic [31:0] m_fa;
  logic [1:0]  m_facc;
  logic        m_fpriv;

  function automatic void model_eval(input logic [31:0] a, input logic [1:0] acc, input logic pv,
                                     output logic al, output logic ht, output logic [2:0] rg);
    logic [3:0] p;
    ht = 1'b0; rg = 3'd0; al = 1'b1;
    if (m_glb) begin
      for (int i = 0; i < 8; i++) begin
        if (m_en[i] && m_code[i] >= 5'd4) begin
          longint unsigned sz;
          sz = 64'd1 << (int'(m_code[i]) + 1);
          if (({32'b0, a} / sz) == ({32'b0, m_base[i]} / sz)) begin
            ht = 1'b1; rg = 3'(i);
          end
        end
      end
      if (!ht) al = pv;
      else begin
        p = m_perm[rg];
        if (acc[1]) al = pv ? p[1] : p[3];
        else        al = pv ? p[0] : p[2];
        if (acc == 2'b00 && m_xn[rg]) al = 1'b0;
      end
    end
  endfunction

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < 8; i++) begin
        m_en[i] = 0; m_base[i] = 0; m_code[i] = 0; m_perm[i] = 0; m_xn[i] = 0;
      end
      m_glb = 0; m_fv = 0; m_fa = 0; m_facc = 0; m_fpriv = 0;
    end else begin
      logic al, ht, clr;
      logic [2:0] rg;
      model_eval(chk_addr_i, chk_acc_i, chk_priv_i, al, ht, rg);
      clr = cfg_we_i && cfg_addr_i == 5'd17 && cfg_wdata_i[0];
      if (chk_valid_i && !al && (!m_fv || clr)) begin
        m_fv = 1; m_fa = chk_addr_i; m_facc = chk_acc_i; m_fpriv = chk_priv_i;
      end else if (clr) m_fv = 0;
      if (cfg_we_i) begin
        if (cfg_addr_i < 5'd16) begin
          if (!cfg_addr_i[0]) m_base[cfg_addr_i[3:1]] = cfg_wdata_i;
          else begin
            m_en[cfg_addr_i[3:1]]   = cfg_wdata_i[0];
            m_code[cfg_addr_i[3:1]] = cfg_wdata_i[5:1];
            m_perm[cfg_addr_i[3:1]] = cfg_wdata_i[11:8];
            m_xn[cfg_addr_i[3:1]]   = cfg_wdata_i[12];
          end
        end else if (cfg_addr_i == 5'd16) m_glb = cfg_wdata_i[0];
      end
    end
  end

  task automatic check_eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // every clock: comb outputs and status against the model
  always @(negedge clk_i) begin
    #6;
    if (run) begin
      logic al, ht;
      logic [2:0] rg;
      if (chk_valid_i) begin
        model_eval(chk_addr_i, chk_acc_i, chk_priv_i, al, ht, rg);
        check_eq("R4/R5 model access", {28'b0, chk_allow_o, chk_fault_o, chk_hit_o, 1'b0},
                 {28'b0, al, !al, ht, 1'b0});
        if (ht) check_eq("R4 model region", 32'(chk_region_o), 32'(rg));
      end
      check_eq("R8 model status", {28'b0, flt_priv_o & m_fv, flt_acc_o & {2{m_fv}}, flt_valid_o},
               {28'b0, m_fpriv & m_fv, m_facc & {2{m_fv}}, m_fv});
      if (m_fv) check_eq("R8 model fault addr", flt_addr_o, m_fa);
    end
  end

  task automatic cfg_write(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk_i);
    chk_valid_i = 0; cfg_we_i = 1; cfg_addr_i = a; cfg_wdata_i = d;
    @(negedge clk_i);
    cfg_we_i = 0;
  endtask

  task automatic cfg_read(input logic [4:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk_i);
    chk_valid_i = 0; cfg_we_i = 0; cfg_addr_i = a;
    #5 check_eq(tag, cfg_rdata_o, exp);
  endtask

  task automatic access(input logic [31:0] a, input logic [1:0] acc, input logic pv,
                        input logic e_al, input logic e_ht, input logic [2:0] e_rg, input string tag);
    @(negedge clk_i);
    chk_valid_i = 1; chk_addr_i = a; chk_acc_i = acc; chk_priv_i = pv;
    #5;
    check_eq(tag, {29'b0, chk_allow_o, chk_fault_o, chk_hit_o}, {29'b0, e_al, !e_al, e_ht});
    if (e_ht) check_eq({tag, " region"}, 32'(chk_region_o), 32'(e_rg));
  endtask

  task automatic status_chk(input logic e_v, input logic [31:0] e_a, input logic [1:0] e_acc,
                            input logic e_p, input string tag);
    @(negedge clk_i);
    chk_valid_i = 0;
    #5;
    check_eq(tag, 32'(flt_valid_o), 32'(e_v));
    if (e_v) check_eq({tag, " addr/acc/priv"}, {flt_addr_o[28:0], flt_acc_o, flt_priv_o},
                      {e_a[28:0], e_acc, e_p});
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    n_chk++; n_err++;
    $display("FAIL watchdog expired at %0t", $time);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    run = 1;
    // R1 reset state
    cfg_read(5'd0, 32'h0, "R1 region0 base");
    cfg_read(5'd15, 32'h0, "R1 region7 attr");
    cfg_read(5'd16, 32'h0, "R1 control");
    cfg_read(5'd17, 32'h0, "R1 status");
    access(32'h4000_0000, 2'b10, 1'b0, 1'b1, 1'b0, 3'd0, "R1 disabled allows");

    // region programming
    cfg_write(5'd0, 32'h0000_0000); cfg_write(5'd1, 32'h0000_071F);
    cfg_write(5'd2, 32'h0000_10FF); cfg_write(5'd3, 32'h0000_010F);
    cfg_write(5'd4, 32'h2000_0000); cfg_write(5'd5, 32'h0000_1F17);
    cfg_write(5'd6, 32'h4000_0000); cfg_write(5'd7, 32'h0000_0F05);
    cfg_write(5'd10, 32'h8000_0000); cfg_write(5'd11, 32'h0000_0F3E);
    access(32'h4000_0000, 2'b10, 1'b0, 1'b1, 1'b0, 3'd0, "R1 still transparent");
    cfg_write(5'd16, 32'h1);

    cfg_read(5'd2, 32'h0000_10E0, "R3 base low bits dropped");
    cfg_read(5'd3, 32'h0000_010F, "R9 attr readback");
    cfg_read(5'd16, 32'h1, "R9 control readback");

    access(32'h0000_1010, 2'b01, 1'b1, 1'b1, 1'b1, 3'd1, "R4 nested region wins");
    access(32'h0000_1010, 2'b10, 1'b1, 1'b0, 1'b1, 3'd1, "R4 winner denies write");
    status_chk(1'b1, 32'h0000_1010, 2'b10, 1'b1, "R8 first fault captured");
    access(32'h0000_1100, 2'b10, 1'b1, 1'b1, 1'b1, 3'd0, "R3 past 256B end");
    access(32'h0000_1000, 2'b11, 1'b1, 1'b0, 1'b1, 3'd1, "R3 base masked match");
    access(32'h0000_10F0, 2'b01, 1'b0, 1'b0, 1'b1, 3'd1, "R5 user read denied");
    access(32'h0000_2000, 2'b01, 1'b0, 1'b1, 1'b1, 3'd0, "R5 user read");
    access(32'h0000_2000, 2'b10, 1'b0, 1'b0, 1'b1, 3'd0, "R5 user write denied");
    access(32'h2000_0010, 2'b00, 1'b1, 1'b0, 1'b1, 3'd2, "R6 xn fetch");
    access(32'h2000_0010, 2'b01, 1'b1, 1'b1, 1'b1, 3'd2, "R6 xn read ok");
    access(32'h0000_0040, 2'b00, 1'b0, 1'b1, 1'b1, 3'd0, "R6 user fetch");
    access(32'h4000_0000, 2'b01, 1'b0, 1'b0, 1'b0, 3'd0, "R2 tiny code no match");
    access(32'h4000_0000, 2'b01, 1'b1, 1'b1, 1'b0, 3'd0, "R7 priv miss");
    access(32'h0001_0000, 2'b01, 1'b0, 1'b0, 1'b0, 3'd0, "R2 just past 64KB");
    access(32'h8000_0000, 2'b01, 1'b0, 1'b0, 1'b0, 3'd0, "R10 disabled region");
    status_chk(1'b1, 32'h0000_1010, 2'b10, 1'b1, "R8 first fault held");
    cfg_read(5'd17, 32'h0000_000D, "R9 status word");
    cfg_read(5'd18, 32'h0000_1010, "R9 fault address word");

    cfg_write(5'd11, 32'h0000_0F3F);
    access(32'h4000_0000, 2'b01, 1'b0, 1'b1, 1'b1, 3'd5, "R2 4GB region");
    access(32'h0000_1010, 2'b10, 1'b1, 1'b1, 1'b1, 3'd5, "R4 highest wins");
    cfg_write(5'd11, 32'h0000_0F3E);

    cfg_write(5'd17, 32'h1);
    status_chk(1'b0, 32'h0, 2'b00, 1'b0, "R8 cleared");
    @(negedge clk_i);
    chk_valid_i = 0; chk_addr_i = 32'h4000_0000; chk_acc_i = 2'b10; chk_priv_i = 0;
    #5 check_eq("R8 no fault when not valid", 32'(chk_fault_o), 32'h0);
    status_chk(1'b0, 32'h0, 2'b00, 1'b0, "R8 no capture when not valid");
    access(32'h4000_0004, 2'b01, 1'b0, 1'b0, 1'b0, 3'd0, "R7 user miss");
    status_chk(1'b1, 32'h4000_0004, 2'b01, 1'b0, "R8 second capture");
    cfg_write(5'd17, 32'h1);

    for (int k = 0; k < 400; k++) begin
      logic [31:0] a;
      @(negedge clk_i);
      case ($urandom % 4)
        0: a = $urandom & 32'h0000_1FFF;
        1: a = 32'h2000_0000 | ($urandom & 32'h0000_1FFF);
        2: a = 32'h4000_0000 | ($urandom & 32'h0000_00FF);
        default: a = $urandom;
      endcase
      chk_valid_i = ($urandom % 8) != 0;
      chk_addr_i = a;
      chk_acc_i = 2'($urandom);
      chk_priv_i = 1'($urandom);
      cfg_we_i = ($urandom % 16) == 0;
      cfg_addr_i = 5'd17;
      cfg_wdata_i = 32'h1;
    end
    @(negedge clk_i);
    chk_valid_i = 0; cfg_we_i = 0;
    repeat (2) @(negedge clk_i);
    finish_run();
  end
endmodule